// File: doc/BRIEF.md
# Color-Indexed Configuration Register Bank

This block holds the control state of a three-channel imaging front end. A host writes it through a small parallel port made of a 2-bit address, a write strobe and an 8-bit data bus. The host reads it back through the same address and a combinational read bus. The main configuration register carries a color pointer in its top two bits. The pointer selects which color's offset register or gain register receives the next write to the shared offset or gain address. Reads of those addresses also go through the pointer.

A second configuration register, the mode register, is decoded into static control outputs: correlated-double-sampling enable, per-channel enables for single-channel or three-channel operation, span-range selects and clamp mode. The block also gates the input clamp switch combinationally from the sampling clock and the start-of-line input, according to the clamp mode.

Address map: 0 is the main register, 1 is the mode register, 2 is the color offset register, and 3 is the color gain register. Color index 0 is red, 1 is green and 2 is blue. Channel c appears in `offset_o[8c+7:8c]`, `gain_o[4c+3:4c]` and `chan_en_o[c]`.

Top module: `color_cfg_bank`

## Requirements
- R1: A write to address 0 stores the full byte, and a read of address 0 returns it. Main bits 7:6 form the color pointer: 00 red, 01 green, 10 blue, 11 reserved.
- R2: A write to address 2 while the pointer is 0..2 updates only that color's 8-bit offset, and the other two offsets keep their values. A read of address 2 returns the offset of the color the pointer currently selects.
- R3: A write to address 3 while the pointer is 0..2 stores data bits 3:0 as that color's gain and discards bits 7:4. A read of address 3 returns the gain in bits 3:0 and zero in bits 7:4.
- R4: While the pointer is 11, writes to addresses 2 and 3 change no offset and no gain, and reads of addresses 2 and 3 return 0.
- R5: `cds_en_o` equals mode bit 0.
- R6: A write to address 1 also latches the color pointer held at that moment. When mode bit 1 is set, `chan_en_o` has only the bit of the latched color set, or no bit set if the latched code is 11. When mode bit 1 is clear, `chan_en_o` is 111. Later pointer changes do not alter the latched color.
- R7: `span_sel_o` bits 0, 1 and 2 equal mode bits 2 (4 V span), 3 (2 V span) and 4 (external reference span). Mode bit 5 is always stored and read back as 0. Reads of address 1 return the stored mode byte.
- R8: Mode bits 7:6 select the clamp mode: 00 line, 01 pixel, 10 none. With line clamp, `clamp_sw_o` = `samp_clk_i` AND NOT `sol_i`. With pixel clamp, `clamp_sw_o` = `samp_clk_i`. With no clamp, `clamp_sw_o` is 0.
- R9: The reserved clamp code 11 behaves as no clamp, so `clamp_sw_o` is 0.
- R10: While `rst_ni` is low, all registers and the latched pointer are 0. This gives pointer red, sample-and-hold, three channels enabled and line clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe, sampled on rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| samp_clk_i | input | 1 | Sampling clock driving the clamp switch |
| sol_i | input | 1 | Start-of-line indicator |
| cds_en_o | output | 1 | Correlated double sampling enable |
| chan_en_o | output | 3 | Per-channel enables |
| span_sel_o | output | 3 | Span mode enables (4 V, 2 V, external) |
| clamp_sw_o | output | 1 | Input clamp switch control |
| offset_o | output | 24 | Per-color input offsets |
| gain_o | output | 12 | Per-color gains |

## Verification
The routing check sets each of the four pointer codes and then writes a series of distinct offset and gain bytes. The gain bytes have the upper nibble set, so leaked reserved bits would show. After each write the bench compares all three colors, which separates correct routing from a write landing on the wrong color, on all colors, or on none under the reserved code. The mode register is swept through all 256 values under each pointer. After each mode write the bench moves the pointer on, which separates a pointer latched at the mode write from one that tracks the live pointer. The clamp check runs all four clamp codes against every sampling-clock and start-of-line pair, which separates line, pixel and no-clamp gating.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MAIN   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OFFSET = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_GAIN   = 2'd3;

  typedef enum logic [1:0] {
    CLAMP_LINE  = 2'd0,
    CLAMP_PIXEL = 2'd1,
    CLAMP_NONE  = 2'd2,
    CLAMP_RSVD  = 2'd3
  } clamp_e;

  typedef struct packed {
    clamp_e clamp;
    logic   zero5;
    logic   span_ext;
    logic   span_2v;
    logic   span_4v;
    logic   single;
    logic   cds;
  } mode_t;
endpackage

// File: rtl/ccr_host_regs.sv
module ccr_host_regs
  import ccr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    main_o,
  output mode_t                mode_o,
  output logic [PTR_W-1:0]     lat_ptr_o
);
  logic [DATA_W-1:0] main_q;
  mode_t             mode_q;
  logic [PTR_W-1:0]  lat_q;
  logic              we_main, we_mode;

  assign we_main = wr_i && (addr_i == ADDR_MAIN);
  assign we_mode = wr_i && (addr_i == ADDR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      mode_q <= '0;
      lat_q  <= '0;
    end else begin
      if (we_main) main_q <= wdata_i;
      if (we_mode) begin
        mode_q       <= mode_t'(wdata_i);
        mode_q.zero5 <= 1'b0;  // reserved bit forced low
        lat_q        <= main_q[DATA_W-1 -: PTR_W];
      end
    end
  end

  assign main_o    = main_q;
  assign mode_o    = mode_q;
  assign lat_ptr_o = lat_q;

  assert_mode_bit5_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_mode |=> (mode_o.zero5 == 1'b0));
  assert_lat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_mode |=> $stable(lat_ptr_o));
  assert_main_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_main |=> $stable(main_o));
endmodule

// File: rtl/ccr_color_bank.sv
module ccr_color_bank
  import ccr_pkg::*;
#(
  parameter int NUM_COLORS = 3,
  parameter int GAIN_W     = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_off_i,
  input  logic                           we_gain_i,
  input  logic [PTR_W-1:0]               ptr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_COLORS*DATA_W-1:0]   offset_o,
  output logic [NUM_COLORS*GAIN_W-1:0]   gain_o,
  output logic [DATA_W-1:0]              rd_off_o,
  output logic [GAIN_W-1:0]              rd_gain_o
);
  logic [DATA_W-1:0] off_q  [NUM_COLORS];
  logic [GAIN_W-1:0] gain_q [NUM_COLORS];

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
    logic sel;
    assign sel = (ptr_i == PTR_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q[c]  <= '0;
        gain_q[c] <= '0;
      end else begin
        if (we_off_i && sel)  off_q[c]  <= wdata_i;
        if (we_gain_i && sel) gain_q[c] <= wdata_i[GAIN_W-1:0];
      end
    end

    assign offset_o[c*DATA_W +: DATA_W] = off_q[c];
    assign gain_o[c*GAIN_W +: GAIN_W]   = gain_q[c];

    assert_off_isolate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_off_i && (ptr_i != PTR_W'(c))) |=> $stable(offset_o[c*DATA_W +: DATA_W]));
    assert_gain_isolate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_gain_i && (ptr_i != PTR_W'(c))) |=> $stable(gain_o[c*GAIN_W +: GAIN_W]));
    assert_rsvd_ptr_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((we_off_i || we_gain_i) && (ptr_i == '1)) |=>
        ($stable(offset_o[c*DATA_W +: DATA_W]) && $stable(gain_o[c*GAIN_W +: GAIN_W])));
  end

  always_comb begin
    rd_off_o  = '0;  // reserved pointer reads zero
    rd_gain_o = '0;
    for (int c = 0; c < NUM_COLORS; c++) begin
      if (ptr_i == PTR_W'(c)) begin
        rd_off_o  = off_q[c];
        rd_gain_o = gain_q[c];
      end
    end
  end
endmodule

// File: rtl/ccr_mode_decode.sv
module ccr_mode_decode
  import ccr_pkg::*;
#(
  parameter int NUM_COLORS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  mode_t                 mode_i,
  input  logic [PTR_W-1:0]      lat_ptr_i,
  output logic                  cds_en_o,
  output logic [NUM_COLORS-1:0] chan_en_o,
  output logic [2:0]            span_sel_o,
  output clamp_e                clamp_o
);
  assign cds_en_o   = mode_i.cds;
  assign span_sel_o = {mode_i.span_ext, mode_i.span_2v, mode_i.span_4v};
  assign clamp_o    = mode_i.clamp;

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_chan
    assign chan_en_o[c] = !mode_i.single || (lat_ptr_i == PTR_W'(c));
  end

  assert_chan_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i.single ? $onehot0(chan_en_o) : ($countones(chan_en_o) == NUM_COLORS));
endmodule

// File: rtl/ccr_clamp_gate.sv
module ccr_clamp_gate
  import ccr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  clamp_e clamp_i,
  input  logic   samp_clk_i,
  input  logic   sol_i,
  output logic   clamp_sw_o
);
  always_comb begin
    unique case (clamp_i)
      CLAMP_LINE:  clamp_sw_o = samp_clk_i && !sol_i;
      CLAMP_PIXEL: clamp_sw_o = samp_clk_i;
      default:     clamp_sw_o = 1'b0;  // none and reserved
    endcase
  end

  assert_no_clamp_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_i == CLAMP_NONE || clamp_i == CLAMP_RSVD) |-> !clamp_sw_o);
  assert_line_sol_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_i == CLAMP_LINE && sol_i) |-> !clamp_sw_o);
endmodule

// File: rtl/color_cfg_bank.sv
module color_cfg_bank
  import ccr_pkg::*;
#(
  parameter int NUM_COLORS = 3,
  parameter int GAIN_W     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic                          samp_clk_i,
  input  logic                          sol_i,
  output logic                          cds_en_o,
  output logic [NUM_COLORS-1:0]         chan_en_o,
  output logic [2:0]                    span_sel_o,
  output logic                          clamp_sw_o,
  output logic [NUM_COLORS*DATA_W-1:0]  offset_o,
  output logic [NUM_COLORS*GAIN_W-1:0]  gain_o
);
  logic [DATA_W-1:0] main_q;
  mode_t             mode_q;
  logic [PTR_W-1:0]  lat_ptr, ptr;
  logic [DATA_W-1:0] rd_off;
  logic [GAIN_W-1:0] rd_gain;
  clamp_e            clamp;

  assign ptr = main_q[DATA_W-1 -: PTR_W];

  ccr_host_regs i_host_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .main_o(main_q), .mode_o(mode_q), .lat_ptr_o(lat_ptr)
  );

  ccr_color_bank #(.NUM_COLORS(NUM_COLORS), .GAIN_W(GAIN_W)) i_color_bank (
    .clk_i, .rst_ni,
    .we_off_i (wr_i && (addr_i == ADDR_OFFSET)),
    .we_gain_i(wr_i && (addr_i == ADDR_GAIN)),
    .ptr_i    (ptr),
    .wdata_i,
    .offset_o, .gain_o,
    .rd_off_o (rd_off),
    .rd_gain_o(rd_gain)
  );

  ccr_mode_decode #(.NUM_COLORS(NUM_COLORS)) i_mode_decode (
    .clk_i, .rst_ni,
    .mode_i(mode_q), .lat_ptr_i(lat_ptr),
    .cds_en_o, .chan_en_o, .span_sel_o,
    .clamp_o(clamp)
  );

  ccr_clamp_gate i_clamp_gate (
    .clk_i, .rst_ni,
    .clamp_i(clamp), .samp_clk_i, .sol_i, .clamp_sw_o
  );

  always_comb begin
    unique case (addr_i)
      ADDR_MAIN:   rdata_o = main_q;
      ADDR_MODE:   rdata_o = mode_q;
      ADDR_OFFSET: rdata_o = rd_off;
      default:     rdata_o = DATA_W'(rd_gain);
    endcase
  end

  assert_gain_rd_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_GAIN) |-> (rdata_o[DATA_W-1:GAIN_W] == '0));
  assert_cds_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_MODE) |=> (cds_en_o == $past(wdata_i[0])));
  assert_span_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_MODE) |=> (span_sel_o == $past(wdata_i[4:2])));
endmodule

// File: tb/test_color_cfg_bank.sv
module test_color_cfg_bank;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_ni = 0;
  logic [1:0]  addr = 0;
  logic        wr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        samp = 0, sol = 0;
  logic        cds_en, clamp_sw;
  logic [2:0]  chan_en, span_sel;
  logic [23:0] offset;
  logic [11:0] gain;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_main, m_mode;
  logic [7:0] m_off [3];
  logic [3:0] m_gain [3];
  logic [1:0] m_lat;

  color_cfg_bank i_color_cfg_bank (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .samp_clk_i(samp), .sol_i(sol), .cds_en_o(cds_en), .chan_en_o(chan_en),
    .span_sel_o(span_sel), .clamp_sw_o(clamp_sw), .offset_o(offset), .gain_o(gain)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_main = 0; m_mode = 0; m_lat = 0;
    for (int c = 0; c < 3; c++) begin m_off[c] = 0; m_gain[c] = 0; end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    logic [1:0] p;
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    p = m_main[7:6];
    case (a)
      2'd0: m_main = d;
      2'd1: begin m_mode = d & 8'hDF; m_lat = p; end
      2'd2: if (p != 3) m_off[p] = d;
      default: if (p != 3) m_gain[p] = d[3:0];
    endcase
  endtask

  function automatic logic [2:0] exp_chan();
    if (!m_mode[1]) return 3'b111;
    if (m_lat == 3) return 3'b000;
    return 3'(1 << m_lat);
  endfunction

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic chk_bank();
    for (int c = 0; c < 3; c++) begin
      chk("R2 offset", offset[8*c +: 8], m_off[c]);
      chk("R3 gain", gain[4*c +: 4], m_gain[c]);
    end
    if (m_main[7:6] == 3) begin
      rd_chk("R4 rsvd offset read", 2'd2, 8'h00);
      rd_chk("R4 rsvd gain read", 2'd3, 8'h00);
    end else begin
      rd_chk("R2 offset read", 2'd2, m_off[m_main[7:6]]);
      rd_chk("R3 gain read", 2'd3, {4'h0, m_gain[m_main[7:6]]});
    end
  endtask

  task automatic chk_mode();
    chk("R5 cds", cds_en, m_mode[0]);
    chk("R6 chan_en", chan_en, exp_chan());
    chk("R7 span", span_sel, m_mode[4:2]);
    rd_chk("R7 mode read", 2'd1, m_mode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 offsets", offset, 0);
    chk("R10 gains", gain, 0);
    chk("R10 cds", cds_en, 0);
    chk("R10 chan_en", chan_en, 3'b111);
    chk("R10 span", span_sel, 0);
    samp = 1; sol = 0; #1;
    chk("R10 line clamp", clamp_sw, 1);
    samp = 0;
    rst_ni = 1;
    @(negedge clk);
    rd_chk("R10 main read", 2'd0, 8'h00);

    // R1/R2/R3/R4: pointer routing sweep
    for (int p = 0; p < 4; p++) begin
      wr_reg(2'd0, 8'((p << 6) | (p * 13 + 5)));
      rd_chk("R1 main read", 2'd0, m_main);
      for (int k = 0; k < 16; k++) begin
        wr_reg(2'd2, 8'((p * 67 + k * 17 + 1) & 255));
        chk_bank();
        wr_reg(2'd3, 8'((k * 37 + p * 11) | 8'hF0));
        chk_bank();
      end
    end

    // R5/R6/R7: mode sweep with pointer moved after each mode write
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 256; m++) begin
        wr_reg(2'd0, 8'(p << 6));
        wr_reg(2'd1, 8'(m));
        chk_mode();
        wr_reg(2'd0, 8'(((p + 1) % 4) << 6));
        chk("R6 latched chan_en", chan_en, exp_chan());
      end
    end

    // R8/R9: clamp gating
    for (int cm = 0; cm < 4; cm++) begin
      wr_reg(2'd1, 8'(cm << 6));
      for (int s = 0; s < 4; s++) begin
        logic e;
        samp = s[0]; sol = s[1]; #1;
        case (cm)
          0: e = samp && !sol;
          1: e = samp;
          default: e = 1'b0;
        endcase
        chk(cm == 3 ? "R9 reserved clamp" : "R8 clamp gate", clamp_sw, e);
      end
    end
    samp = 0; sol = 0;

    // R10: asynchronous reset mid-run
    wr_reg(2'd0, 8'h40);
    wr_reg(2'd2, 8'hA5);
    wr_reg(2'd1, 8'h03);
    #2 rst_ni = 0; #1;
    chk("R10 async offsets", offset, 0);
    chk("R10 async chan_en", chan_en, 3'b111);
    chk("R10 async cds", cds_en, 0);
    model_reset();
    @(negedge clk); rst_ni = 1;
    rd_chk("R10 async main read", 2'd0, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule